// File: doc/BRIEF.md
# Digitally Controlled Reference Phase Shifter

This block produces a phase-adjusted copy of a square-wave demodulation reference. The reference enters asynchronously and is first synchronised into a fast sampling clock domain. It then runs down a tapped shift-register delay line clocked by the same fast clock. A 9-bit coefficient picks the tap with its low eight bits and can invert the selected tap with its top bit. The inversion gives a half-cycle (180 degree) shift, and the tap gives up to 255 extra fast-clock periods of delay.

The delay is counted in clock periods, so the phase angle it gives depends on the reference frequency. With a fast clock of about 3 ns, the full tap range covers roughly 768 ns. A synchronous demodulator downstream uses the output to line up its reference with the sensor signal.

The coefficient is sampled on every fast clock edge. A change therefore retunes the phase while the reference keeps running, and the delay line is not cleared when that happens.

Top module: `ref_phase_shifter`

## Requirements
- R1: While rst_n is low, ref_out is 0 and the internal coefficient register holds 0, whatever ref_in and coef_in do.
- R2: When coefficient bit 8 is 1, ref_out is the logical inverse of the delayed reference that the same low bits would give with bit 8 at 0; the inversion is applied after tap selection.
- R3: With the coefficient held, the ref_in value sampled at fast clock edge n appears on ref_out right after edge n+2+T, where T is the unsigned value of coefficient bits 7:0.
- R4: Tap value T=0 gives the minimum latency of 2 edges with no delay-line stage in the path, and T=255 gives the maximum of 257 edges.
- R5: coef_in is captured on every fast clock edge; the value captured at edge n controls the ref_out value produced at edge n+1.
- R6: A coefficient change does not clear the delay line; right after the change, ref_out shows the reference history already stored at the newly selected tap.
- R7: Each reference pulse of W fast-clock periods appears on ref_out as a pulse of exactly W periods, with both of its edges delayed by the same amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast sampling clock that steps the delay line |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_in | input | 1 | Square-wave reference, asynchronous to clk_fast |
| coef_in | input | 9 | Phase coefficient: bit 8 inverts, bits 7:0 select the delay tap |
| ref_out | output | 1 | Phase-adjusted reference, registered |

## Verification
The ref_out value after edge m follows from two earlier samples: the coefficient taken at edge m-1, and the ref_in sample taken at edge m-2-T for the tap T in that coefficient. The bench logs ref_in and coef_in at every rising edge into rings. Each ref_out sample taken at the falling edge is compared with the value those rings give for exactly that lag, so both the extra cycle of coefficient latency and the tap latency are checked on every cycle. Directed pulses measure the first falling edge at which the output moves (2+T+1 falling edges after ref_in is driven) and the pulse width. These measurements are made for the minimum and maximum taps, with and without inversion.

// File: rtl/phsh_pkg.sv
package phsh_pkg;
  // Default geometry of the reference phase shifter.
  parameter int unsigned PHSH_TAP_W_DEF = 8;
  parameter int unsigned PHSH_SYNC_DEF  = 2;

  // Number of selectable delay positions for a given tap select width.
  function automatic int unsigned phsh_positions(input int unsigned tap_w);
    return 32'd1 << tap_w;
  endfunction

  // Number of physical delay stages: position 0 is the undelayed signal.
  function automatic int unsigned phsh_line_len(input int unsigned tap_w);
    return (32'd1 << tap_w) - 32'd1;
  endfunction
endpackage

// File: rtl/phsh_sync.sv
module phsh_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      logic q_nxt;
      always_comb begin
        q_nxt = din;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_nxt;
      end
      assign dout = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      logic [STAGES-1:0] q_nxt;
      always_comb begin
        q_nxt = {q[STAGES-2:0], din};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
      end
      assign dout = q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/phsh_coef_reg.sv
module phsh_coef_reg #(
  parameter int unsigned COEF_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COEF_W-1:0] coef_d,
  output logic [COEF_W-1:0] coef_q
);
  // Coefficient is reloaded on every edge; the load enable is constant.
  logic              load_en;
  logic [COEF_W-1:0] coef_nxt;

  assign load_en = 1'b1;

  always_comb begin
    coef_nxt = coef_q;
    if (load_en) coef_nxt = coef_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coef_q <= '0;
    else        coef_q <= coef_nxt;
  end
endmodule

// File: rtl/phsh_delay_line.sv
module phsh_delay_line #(
  parameter int unsigned LEN = 255
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           din,
  output logic [LEN-1:0] stages
);
  logic [LEN-1:0] stages_nxt;
  logic           shift_en;

  assign shift_en = 1'b1;

  generate
    if (LEN == 1) begin : g_one
      always_comb begin
        stages_nxt = stages;
        if (shift_en) stages_nxt = din;
      end
    end else begin : g_many
      always_comb begin
        stages_nxt = stages;
        if (shift_en) stages_nxt = {stages[LEN-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stages <= '0;
    else        stages <= stages_nxt;
  end
endmodule

// File: rtl/phsh_tap_sel.sv
module phsh_tap_sel #(
  parameter int unsigned TAP_W = 8,
  localparam int unsigned POS  = 1 << TAP_W,
  localparam int unsigned LEN  = POS - 1
) (
  input  logic             undelayed,
  input  logic [LEN-1:0]   stages,
  input  logic [TAP_W-1:0] sel,
  output logic             tapped
);
  // Position 0 is the undelayed input, position k is stage k-1.
  logic [POS-1:0] positions;

  assign positions = {stages, undelayed};

  always_comb begin
    tapped = positions[sel];
  end
endmodule

// File: rtl/ref_phase_shifter.sv
module ref_phase_shifter #(
  parameter int unsigned TAP_W       = phsh_pkg::PHSH_TAP_W_DEF,
  parameter int unsigned SYNC_STAGES = phsh_pkg::PHSH_SYNC_DEF,
  localparam int unsigned COEF_W     = TAP_W + 1,
  localparam int unsigned LINE_LEN   = phsh_pkg::phsh_line_len(TAP_W)
) (
  input  logic              clk_fast,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic [COEF_W-1:0] coef_in,
  output logic              ref_out
);
  logic                ref_sync;
  logic [COEF_W-1:0]   coef_q;
  logic [LINE_LEN-1:0] line_q;
  logic                tap_bit;
  logic                invert;
  logic [TAP_W-1:0]    tap_sel;
  logic                out_nxt;

  phsh_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk_fast),
    .rst_n(rst_n),
    .din  (ref_in),
    .dout (ref_sync)
  );

  phsh_coef_reg #(.COEF_W(COEF_W)) u_coef (
    .clk   (clk_fast),
    .rst_n (rst_n),
    .coef_d(coef_in),
    .coef_q(coef_q)
  );

  phsh_delay_line #(.LEN(LINE_LEN)) u_line (
    .clk   (clk_fast),
    .rst_n (rst_n),
    .din   (ref_sync),
    .stages(line_q)
  );

  assign tap_sel = coef_q[TAP_W-1:0];
  assign invert  = coef_q[COEF_W-1];

  phsh_tap_sel #(.TAP_W(TAP_W)) u_tap (
    .undelayed(ref_sync),
    .stages   (line_q),
    .sel      (tap_sel),
    .tapped   (tap_bit)
  );

  // Inversion sits after the tap multiplexer.
  always_comb begin
    out_nxt = tap_bit ^ invert;
  end

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) ref_out <= 1'b0;
    else        ref_out <= out_nxt;
  end
endmodule

// File: rtl/ref_phase_shifter_chk.sv
module ref_phase_shifter_chk #(
  parameter int unsigned TAP_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned COEF_W     = TAP_W + 1,
  localparam int unsigned HIST       = SYNC_STAGES + (1 << TAP_W)
) (
  input logic              clk_fast,
  input logic              rst_n,
  input logic              ref_in,
  input logic [COEF_W-1:0] coef_in,
  input logic              ref_out,
  input logic [COEF_W-1:0] coef_q
);
  // Independent history of the reference and two-deep history of coef_in.
  logic [HIST-1:0]   hist;
  logic [COEF_W-1:0] cin_d1;
  logic [COEF_W-1:0] cin_d2;
  logic              model_bit;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      hist   <= '0;
      cin_d1 <= '0;
      cin_d2 <= '0;
    end else begin
      hist   <= {hist[HIST-2:0], ref_in};
      cin_d1 <= coef_in;
      cin_d2 <= cin_d1;
    end
  end

  assign model_bit = hist[SYNC_STAGES + int'(cin_d2[TAP_W-1:0])];

  assert_reset_clear_R1: assert property (@(posedge clk_fast)
    !rst_n |-> (ref_out == 1'b0 && coef_q == '0));

  assert_plain_delay_R3: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !cin_d2[COEF_W-1] |-> ref_out == model_bit);

  assert_inverted_delay_R2: assert property (@(posedge clk_fast) disable iff (!rst_n)
    cin_d2[COEF_W-1] |-> ref_out == !model_bit);

  assert_coef_capture_R5: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $past(rst_n) |-> coef_q == $past(coef_in));
endmodule

bind ref_phase_shifter ref_phase_shifter_chk #(
  .TAP_W      (TAP_W),
  .SYNC_STAGES(SYNC_STAGES)
) i_chk (
  .clk_fast(clk_fast),
  .rst_n   (rst_n),
  .ref_in  (ref_in),
  .coef_in (coef_in),
  .ref_out (ref_out),
  .coef_q  (coef_q)
);

// File: tb/test_ref_phase_shifter.sv
module test_ref_phase_shifter;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int RING       = 1024;

  logic       clk_fast = 1'b0;
  logic       rst_n    = 1'b0;
  logic       ref_in   = 1'b0;
  logic [8:0] coef_in  = 9'd0;
  logic       ref_out;

  int total = 0;
  int bad   = 0;
  int edge_n = 0;
  bit done = 0;

  logic       ring_ref  [RING];
  logic [8:0] ring_coef [RING];

  ref_phase_shifter i_ref_phase_shifter (
    .clk_fast(clk_fast),
    .rst_n   (rst_n),
    .ref_in  (ref_in),
    .coef_in (coef_in),
    .ref_out (ref_out)
  );

  always #(CLK_PERIOD/2) clk_fast = ~clk_fast;

  // Log what each rising edge samples; reset edges count as zeros.
  always @(posedge clk_fast) begin
    ring_ref[edge_n % RING]  <= rst_n ? ref_in : 1'b0;
    ring_coef[edge_n % RING] <= rst_n ? coef_in : 9'd0;
    edge_n <= edge_n + 1;
  end

  // Expected ref_out after the most recent edge m (R3, R5, R2).
  function automatic logic expected_out();
    int m;
    int idx;
    logic [8:0] c;
    logic r;
    m = edge_n - 1;
    if (m < 1) return 1'b0;
    c = ring_coef[(m - 1) % RING];
    idx = m - SYNC - int'(c[7:0]);
    r = (idx < 0) ? 1'b0 : ring_ref[idx % RING];
    return r ^ c[8];
  endfunction

  function automatic string tag_for(input logic [8:0] c);
    if (c[8]) return "R2";
    if (c[7:0] == 8'd0 || c[7:0] == 8'd255) return "R4";
    return "R3";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at edge %0d", req, act, exp, edge_n);
    end
  endtask

  task automatic cycle(input string req, input logic nref, input logic [8:0] ncoef);
    @(negedge clk_fast);
    check(req, int'(ref_out), int'(expected_out()));
    ref_in  = nref;
    coef_in = ncoef;
  endtask

  // Square wave with the given half period under a fixed coefficient.
  task automatic sweep(input logic [8:0] c, input int half, input int n);
    string t;
    t = tag_for(c);
    for (int k = 0; k < n; k++) cycle(t, ((k / half) % 2) == 1, c);
  endtask

  // R7/R4: output pulse latency and width for one coefficient.
  task automatic pulse(input logic [8:0] c, input int w);
    int first;
    int width;
    logic act_lvl;
    first = -1;
    width = 0;
    act_lvl = ~c[8];
    for (int k = 0; k < 300; k++) cycle("R7", 1'b0, c);
    @(negedge clk_fast);
    ref_in = 1'b1;
    for (int k = 1; k <= 320; k++) begin
      @(negedge clk_fast);
      if (ref_out == act_lvl) begin
        if (first < 0) first = k;
        width++;
      end
      if (k == w) ref_in = 1'b0;
    end
    check((c[7:0] == 0 || c[7:0] == 255) ? "R4" : "R7", first, SYNC + int'(c[7:0]) + 1);
    check("R7", width, w);
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);

    // R1: reset holds the output low and the coefficient cleared.
    coef_in = 9'h1FF;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_fast);
      check("R1", int'(ref_out), 0);
      ref_in = k[0];
    end
    rst_n = 1'b1;
    ref_in = 1'b0;
    coef_in = 9'd0;

    // R3/R2/R4: fixed coefficients on square waves of varied period.
    sweep(9'h000, 3, 400);
    sweep(9'h001, 5, 400);
    sweep(9'h007, 4, 400);
    sweep(9'h040, 17, 500);
    sweep(9'h0C8, 23, 600);
    sweep(9'h0FF, 40, 700);
    sweep(9'h100, 3, 400);
    sweep(9'h105, 9, 400);
    sweep(9'h1FF, 31, 700);

    // R7/R4: directed pulse edge positions.
    pulse(9'h000, 6);
    pulse(9'h0FF, 9);
    pulse(9'h100, 5);
    pulse(9'h1FF, 12);
    pulse(9'h023, 1);
    pulse(9'h15A, 20);

    // R5: coefficient step from tap 0 to tap 10 with a running reference.
    for (int k = 0; k < 40; k++) cycle("R5", ((k / 3) % 2) == 1, 9'h000);
    for (int k = 0; k < 40; k++) cycle("R5", ((k / 3) % 2) == 1, 9'h00A);

    // R6: random reference and frequent random coefficient changes.
    begin
      logic [8:0] c;
      logic r;
      c = 9'd0;
      r = 1'b0;
      for (int k = 0; k < 4000; k++) begin
        if (($urandom % 8) == 0) c = 9'($urandom);
        if (($urandom % 4) == 0) r = ~r;
        cycle("R6", r, c);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired, requirement R3 run incomplete actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule